// File: doc/BRIEF.md
# Read Strobe Sample Delay Calculator

This block works out the settings a NAND bus timer needs to run an asynchronous flash interface in its fastest extended-data-out mode. It is given the internal clock period in tenths of a nanosecond, the fast timing mode (4 or 5) and a choice of DLL threshold. From these it computes two things. The first is the delay code for the feedback read strobe. The second is the half-period flag, which tells the delay line to count in half clock periods.

The delay is (tREA + 4 ns - tRP) * 8 / RP, where tRP is one clock period and RP is the reference period of the delay line. tREA is 16 ns in mode 5 and 20 ns in mode 4. RP is half the clock period when the clock period exceeds the threshold, and the full period otherwise.

All arithmetic uses tenths of a nanosecond. The quotient is first formed at ten times its final scale and then rounded to the nearest integer. A single restoring divider, which produces one quotient bit per cycle, does both divisions. A caller pulses `start`, waits for the one-cycle `done` pulse, and loads the held outputs into the timer. The same result also fixes the setup and hold cycle counts, the busy timeout and the write-strobe delay select.

Top module: `rd_strobe_delay_calc`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done`, `half_per`, `delay_ovf`, `delay_code` and all cycle-count, timeout and select outputs are zero.
- R2: A `start` sampled while `busy` is low raises `busy` on the next edge. `done` is a one-cycle pulse on the 32nd rising edge after the edge that sampled `start`, and `busy` falls on that same edge.
- R3: A `start` pulse while `busy` is high is ignored: the result that follows belongs to the inputs captured by the accepted start.
- R4: `half_per` is 1 exactly when `period_dns` is greater than the threshold. The threshold is 160 (16 ns) when `thr_sel` = 0 and 120 (12 ns) when `thr_sel` = 1. RP is floor(`period_dns`/2) when `half_per` is 1, and `period_dns` otherwise.
- R5: With T = 200 for `mode5` = 1 and T = 240 for `mode5` = 0 (tREA + 4 ns, in tenths), the block forms q = floor((T - `period_dns`) * 80 / RP). It then outputs `delay_code` = floor((q + 5) / 10).
- R6: When `period_dns` >= T, `delay_code` is 0 and `delay_ovf` is 0.
- R7: When the rounded value exceeds 2^DW - 1 (15 by default), `delay_code` is 2^DW - 1 and `delay_ovf` is 1. A `period_dns` of 0 always gives this saturated result.
- R8: At completion `data_setup` = 1, `data_hold` = 1, `addr_setup` = 1 in mode 5 and 0 in mode 4, `busy_tmo` = 0x9000 and `wr_dly_sel` = 2'b11 (no write-strobe delay).
- R9: All result outputs hold their values from one completion to the next, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation; inputs are captured on this edge |
| period_dns | input | PW (12) | Internal clock period in tenths of a nanosecond |
| mode5 | input | 1 | 1 selects timing mode 5, 0 selects mode 4 |
| thr_sel | input | 1 | 0 selects a 16 ns DLL threshold, 1 selects 12 ns |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| data_setup | output | CW (8) | Data setup cycle count |
| data_hold | output | CW (8) | Data hold cycle count |
| addr_setup | output | CW (8) | Address setup cycle count |
| busy_tmo | output | 16 | Ready/busy timeout value |
| wr_dly_sel | output | 2 | Write-strobe delay select |
| half_per | output | 1 | Delay line counts half periods |
| delay_code | output | DW (4) | Rounded read-strobe sample delay code |
| delay_ovf | output | 1 | Delay saturated to the field maximum |

## Verification
A corrupt remainder, quotient or step counter inside the divider is visible only once the run ends. It shows up as a wrong `delay_code` or `delay_ovf`, or as a `done` pulse that comes earlier or later than the 32nd edge. Every run is therefore compared against a model, and its latency is counted. A wrongly captured half-period decision or threshold appears at the same edge in `half_per` and also skews the code. This is why the period is swept across both thresholds and through the zero and negative-margin regions.

// File: rtl/rd_strobe_delay_calc.sv
module rd_strobe_delay_calc #(
  parameter int PW = 12,
  parameter int DW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] period_dns,
  input  logic          mode5,
  input  logic          thr_sel,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] data_setup,
  output logic [CW-1:0] data_hold,
  output logic [CW-1:0] addr_setup,
  output logic [15:0]   busy_tmo,
  output logic [1:0]    wr_dly_sel,
  output logic          half_per,
  output logic [DW-1:0] delay_code,
  output logic          delay_ovf
);
  localparam int NW   = 16;
  localparam int CNTW = $clog2(NW);
  localparam logic [DW-1:0] MAXC = '1;

  typedef enum logic [1:0] {S_IDLE, S_QUO, S_RND} st_t;
  st_t st;

  logic [NW:0]     rem;
  logic [NW-1:0]   quo, dvs;
  logic [CNTW-1:0] cnt;
  logic            half_q, m5_q;

  wire [NW-1:0] per_x = {{(NW-PW){1'b0}}, period_dns};
  wire [NW-1:0] trc   = mode5 ? 16'd200 : 16'd240;
  wire [NW-1:0] thr   = thr_sel ? 16'd120 : 16'd160;
  wire          slow  = per_x > thr;
  wire [NW-1:0] rp    = slow ? (per_x >> 1) : per_x;
  wire [NW-1:0] diff  = trc - per_x;
  wire [NW-1:0] num   = (trc > per_x) ? diff * 16'd80 : '0;

  wire [NW:0]   sh     = {rem[NW-1:0], quo[NW-1]};
  wire          ge     = sh >= {1'b0, dvs};
  wire [NW:0]   rem_nx = ge ? sh - {1'b0, dvs} : sh;
  wire [NW-1:0] quo_nx = {quo[NW-2:0], ge};
  wire          last   = cnt == CNTW'(NW - 1);
  wire [NW-1:0] q_rnd  = (&quo_nx) ? quo_nx : quo_nx + 16'd5;
  wire          big    = quo_nx > {{(NW-DW){1'b0}}, MAXC};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rem <= '0;
      quo <= '0;
      dvs <= '0;
      cnt <= '0;
      half_q <= 1'b0;
      m5_q <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      data_setup <= '0;
      data_hold <= '0;
      addr_setup <= '0;
      busy_tmo <= '0;
      wr_dly_sel <= '0;
      half_per <= 1'b0;
      delay_code <= '0;
      delay_ovf <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          quo <= num;
          dvs <= rp;
          rem <= '0;
          cnt <= '0;
          half_q <= slow;
          m5_q <= mode5;
          busy <= 1'b1;
          st <= S_QUO;
        end
        S_QUO: begin
          rem <= rem_nx;
          quo <= quo_nx;
          cnt <= cnt + 1'b1;
          if (last) begin
            quo <= q_rnd;
            dvs <= 16'd10;
            rem <= '0;
            cnt <= '0;
            st <= S_RND;
          end
        end
        S_RND: begin
          rem <= rem_nx;
          quo <= quo_nx;
          cnt <= cnt + 1'b1;
          if (last) begin
            st <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
            delay_code <= big ? MAXC : quo_nx[DW-1:0];
            delay_ovf <= big;
            half_per <= half_q;
            data_setup <= CW'(1);
            data_hold <= CW'(1);
            addr_setup <= CW'(m5_q);
            busy_tmo <= 16'h9000;
            wr_dly_sel <= 2'b11;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_strobe_delay_calc_chk.sv
module rd_strobe_delay_calc_chk #(
  parameter int DW = 4,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] data_setup,
  input logic [CW-1:0] data_hold,
  input logic [15:0]   busy_tmo,
  input logic [1:0]    wr_dly_sel,
  input logic          half_per,
  input logic [DW-1:0] delay_code,
  input logic          delay_ovf
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(delay_code) && $stable(delay_ovf) && $stable(half_per)));
  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    delay_ovf |-> (&delay_code));
  assert_fixed_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (data_setup == CW'(1) && data_hold == CW'(1) &&
              busy_tmo == 16'h9000 && wr_dly_sel == 2'b11));
endmodule

bind rd_strobe_delay_calc rd_strobe_delay_calc_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .data_setup(data_setup), .data_hold(data_hold), .busy_tmo(busy_tmo),
  .wr_dly_sel(wr_dly_sel), .half_per(half_per), .delay_code(delay_code),
  .delay_ovf(delay_ovf)
);

// File: tb/rd_strobe_delay_calc_test.sv
`timescale 1ns/1ps
module rd_strobe_delay_calc_test;
  localparam int PW = 12, DW = 4, CW = 8;
  localparam int MAXC = (1 << DW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode5 = 1'b0, thr_sel = 1'b0;
  logic [PW-1:0] period_dns = '0;
  logic busy, done, half_per, delay_ovf;
  logic [CW-1:0] data_setup, data_hold, addr_setup;
  logic [15:0] busy_tmo;
  logic [1:0] wr_dly_sel;
  logic [DW-1:0] delay_code;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rd_strobe_delay_calc #(.PW(PW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .period_dns(period_dns),
    .mode5(mode5), .thr_sel(thr_sel), .busy(busy), .done(done),
    .data_setup(data_setup), .data_hold(data_hold), .addr_setup(addr_setup),
    .busy_tmo(busy_tmo), .wr_dly_sel(wr_dly_sel), .half_per(half_per),
    .delay_code(delay_code), .delay_ovf(delay_ovf));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int p, input bit m5, input bit ts,
                                output int code, output bit ovf, output bit half);
    int trc, thr, rp, q, r;
    trc = m5 ? 200 : 240;
    thr = ts ? 120 : 160;
    half = p > thr;
    rp = half ? p / 2 : p;
    if (trc <= p) q = 0;
    else if (rp == 0) q = 65535;
    else q = (trc - p) * 80 / rp;
    r = (q == 65535) ? 6553 : (q + 5) / 10;
    ovf = r > MAXC;
    code = ovf ? MAXC : r;
  endfunction

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input int p, input bit m5, input bit ts, input string tag);
    int code; bit ovf, half;
    model(p, m5, ts, code, ovf, half);
    chk(delay_code == code, {tag, " code"}, delay_code, code);
    chk(delay_ovf == ovf, {tag, " ovf"}, delay_ovf, ovf);
    chk(half_per == half, "R4 half", half_per, half);
  endtask

  task automatic run(input int p, input bit m5, input bit ts, input string tag);
    int lat;
    @(negedge clk);
    period_dns = PW'(p); mode5 = m5; thr_sel = ts; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    wait_done(lat);
    chk(lat == 32, "R2 latency", lat, 32);
    check_result(p, m5, ts, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat, code; bit ovf, half;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({busy, done, half_per, delay_ovf} == 4'b0, "R1 flags", {busy, done, half_per, delay_ovf}, 0);
    chk(delay_code == 0 && busy_tmo == 0 && data_setup == 0 && wr_dly_sel == 0,
        "R1 values", delay_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && delay_code == 0 && addr_setup == 0, "R1 after release", busy, 0);

    run(100, 1'b1, 1'b0, "R5 m5 p100");
    chk(delay_code == 8, "R5 m5 p100 direct", delay_code, 8);
    chk(data_setup == 1 && data_hold == 1, "R8 setup/hold", data_setup, 1);
    chk(addr_setup == 1, "R8 addr mode5", addr_setup, 1);
    chk(busy_tmo == 16'h9000, "R8 timeout", busy_tmo, 16'h9000);
    chk(wr_dly_sel == 2'b11, "R8 wr sel", wr_dly_sel, 3);
    run(125, 1'b0, 1'b0, "R5 m4 p125");
    chk(delay_code == 7, "R5 m4 p125 direct", delay_code, 7);
    chk(addr_setup == 0, "R8 addr mode4", addr_setup, 0);
    run(170, 1'b0, 1'b0, "R4 half 16ns");
    chk(half_per == 1 && delay_code == 7, "R4 p170 direct", delay_code, 7);
    run(130, 1'b0, 1'b1, "R4 12ns thr");
    chk(half_per == 1, "R4 p130 thr12", half_per, 1);
    run(130, 1'b0, 1'b0, "R4 16ns thr");
    chk(half_per == 0, "R4 p130 thr16", half_per, 0);
    run(160, 1'b0, 1'b0, "R4 at thr");
    chk(half_per == 0, "R4 equal not half", half_per, 0);
    run(240, 1'b0, 1'b0, "R6 zero margin");
    chk(delay_code == 0 && delay_ovf == 0, "R6 p240", delay_code, 0);
    run(300, 1'b1, 1'b1, "R6 negative");
    chk(delay_code == 0 && delay_ovf == 0, "R6 p300", delay_code, 0);
    run(50, 1'b0, 1'b0, "R7 overflow");
    chk(delay_code == MAXC && delay_ovf == 1, "R7 p50", delay_code, MAXC);
    run(0, 1'b1, 1'b0, "R7 zero period");
    chk(delay_code == MAXC && delay_ovf == 1, "R7 p0", delay_code, MAXC);

    @(negedge clk);
    period_dns = 12'd100; mode5 = 1'b1; thr_sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    period_dns = 12'd50; mode5 = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(lat == 26, "R3 latency kept", lat, 26);
    chk(delay_code == 8 && delay_ovf == 0, "R3 busy start ignored", delay_code, 8);
    chk(addr_setup == 1, "R3 mode kept", addr_setup, 1);

    period_dns = 12'd0; mode5 = 1'b0; thr_sel = 1'b1;
    repeat (10) @(negedge clk);
    chk(delay_code == 8 && half_per == 0 && delay_ovf == 0 && addr_setup == 1,
        "R9 outputs held", delay_code, 8);

    for (int i = 0; i < 300; i++) begin
      int p; bit m5, ts;
      p = (i % 3 == 0) ? int'($urandom_range(0, 4095)) : int'($urandom_range(0, 320));
      m5 = 1'(($urandom() >> 3) & 1);
      ts = 1'(($urandom() >> 5) & 1);
      run(p, m5, ts, "R5 random");
      model(p, m5, ts, code, ovf, half);
      if (!ovf && code == 0 && p < (m5 ? 200 : 240) && p > 0) begin
        chk(delay_code == 0, "R5 small margin", delay_code, 0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule